// File: doc/BRIEF.md
# Hot-Swap Insertion and Extraction Sequencer

This block is the control state machine of a telephony bus card that can be plugged into and pulled out of a live backplane. It runs from the long-pin early supply. Its job is to keep the card from disturbing the shared bus while it mates and unmates. Until the card is fully seated and its back-end supply is trusted, it holds every bus driver in tri-state, keeps the clock series-resistor bypass open, leaves precharge bias applied and holds local logic in reset. Once seated, it walks the card up to operation in a fixed order. On removal or power trouble, it walks the card back down.

Full seating is signalled by the short, active-low select pin, which the block synchronizes and debounces. A power-good level from the supply monitor gates back-end power. This level has to be stable for a settle count before the power FETs are enabled. A strap tells the block whether the primary connector is populated as well as the rear one. The strap picks which backplane reset the card obeys, and it allows that reset to be repeated onto the bus reset line. A power-on reset from the early supply forces the safe state asynchronously.

Top module: `hotswap_seq`

## Requirements
- R1: While `por_n` is low, the outputs are held in the safe state, asynchronously and whatever the other inputs do: `data_oe`=0, `netref_oe`=0, `msg_en`=0, `clk_byp`=0, `fet_en`=0, `local_rst_n`=0, `pchg_en`=1, `led`=1.
- R2: The select pin passes through a two-flop synchronizer and a debouncer. The debounced value changes only after the synchronized value has differed from it for `DEB_CYC` consecutive cycles, and any return restarts the count. A bounce shorter than that has no effect. A clean change of the pin is acted on by the state register at the (`DEB_CYC`+3)th rising edge after it.
- R3: Insertion runs in this order. Once seated, precharge is dropped if the strap allows it. The FETs turn on only after the synchronized power-good has been high for `SETTLE_CYC` cycles. Local reset is released, and the bus goes live, one cycle after `fet_en` rises.
- R4: Lane i of `data_oe`, plus `netref_oe` and `msg_en`, follow their requests only while the card is installed with local reset released. Otherwise they are 0.
- R5: With `dual_conn`=0 the card obeys `bus_rst_n` and ignores `pri_rst_n`. With `dual_conn`=1 it obeys `pri_rst_n` and ignores `bus_rst_n`. An obeyed reset (low) holds local reset and isolates the bus while the FETs stay on.
- R6: `bus_rst_drive` is 1 exactly when `dual_conn`=1, `rst_repeat_en`=1 and the synchronized `pri_rst_n` is low.
- R7: `clk_byp` is 1 only when `clk_master_req`=1 and the card is installed with local reset released. It is 0 throughout insertion and extraction.
- R8: When the debounced select deasserts, local reset is asserted, the bus isolated and precharge re-applied in the same cycle, with the FETs still on. The FETs turn off one cycle later. Isolation therefore holds `DEB_CYC`+3 cycles after the pin rises.
- R9: In any sequencing state, the synchronized power-good going low turns off the FETs, asserts local reset and isolates the bus in the same cycle. The block then enters a fault state, and leaves it only after a fresh `SETTLE_CYC` of stable power.
- R10: `pchg_en` is 1 except in the seated states with power good and `pchg_drop_en`=1. With `pchg_drop_en`=0 it stays 1 while installed.
- R11: `led` is 1 exactly when the sequencer is in a state with back-end power off (unseated, seated-but-unpowered, fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Early-power clock |
| por_n | input | 1 | Early-power power-on reset, active low, asynchronous |
| sel_n_raw | input | 1 | Raw short-pin board select, active low |
| pwr_good | input | 1 | Back-end supply monitor good level |
| pri_rst_n | input | 1 | Primary connector reset, active low |
| bus_rst_n | input | 1 | Telephony bus reset, active low |
| dual_conn | input | 1 | Strap: 1 = both connectors populated |
| rst_repeat_en | input | 1 | Strap: repeat primary reset onto bus reset |
| pchg_drop_en | input | 1 | Strap: allow precharge removal once seated |
| clk_master_req | input | 1 | Card wants to be bus clock master |
| data_req | input | DATA_W | Per-lane data drive requests from local logic |
| netref_req | input | 1 | Network reference drive request |
| msg_req | input | 1 | Message channel enable request |
| data_oe | output | DATA_W | Per-lane bus data output enables |
| netref_oe | output | 1 | Network reference output enable |
| msg_en | output | 1 | Message channel enable |
| clk_byp | output | 1 | Clock/frame series-resistor bypass switch close |
| pchg_en | output | 1 | Precharge bias enable |
| fet_en | output | 1 | Back-end power FET enable |
| local_rst_n | output | 1 | Local logic reset, active low |
| bus_rst_drive | output | 1 | Pull the bus reset line low (repeat) |
| led | output | 1 | Operator LED, 1 = on |

## Verification
The reset-source selection and its gating are exercised with a table of strap and reset combinations applied to an installed card. Each combination varies the strap, both reset inputs, the repeat strap and the master request. This separates "obeyed reset", "ignored reset", "repeat only with dual" and "bypass only when live". The sequencing itself is driven with a sub-window select bounce, which must leave the card untouched. A clean insertion is then checked at the exact cycles of precharge drop, FET enable and reset release. A mid-operation power loss and recovery checks that the full settle count is enforced again. An extraction checks that reset and isolation come before FET turn-off. A reinsertion with precharge retention and an asynchronous power-on reset close the run.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_UNINST     = 3'd0,
    ST_ISOLATED   = 3'd1,
    ST_POWERING   = 3'd2,
    ST_INSTALLED  = 3'd3,
    ST_EXTRACTING = 3'd4,
    ST_FAULT      = 3'd5
  } hs_state_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // which backplane reset is obeyed, given the population strap
  function automatic logic pick_reset(input logic dual, input logic pri_act,
                                      input logic bus_act);
    return dual ? pri_act : bus_act;
  endfunction

  function automatic logic backend_on(input hs_state_e s);
    return (s == ST_POWERING) || (s == ST_INSTALLED) || (s == ST_EXTRACTING);
  endfunction

  function automatic logic pchg_droppable(input hs_state_e s);
    return (s == ST_ISOLATED) || (s == ST_POWERING) || (s == ST_INSTALLED);
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned   W    = 1,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_debounce.sv
module hs_debounce #(
  parameter int unsigned WINDOW = 50000,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);
  import hs_pkg::*;
  localparam int unsigned CW = cnt_bits(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= INIT;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= din;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hs_rst_sel.sv
module hs_rst_sel (
  input  logic dual_conn,
  input  logic rst_repeat_en,
  input  logic pri_rst_n_s,
  input  logic bus_rst_n_s,
  output logic rst_src,
  output logic rep_drive
);
  import hs_pkg::*;
  always_comb begin
    rst_src   = pick_reset(dual_conn, !pri_rst_n_s, !bus_rst_n_s);
    rep_drive = dual_conn & rst_repeat_en & !pri_rst_n_s;
  end
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm #(
  parameter int unsigned SETTLE_CYC = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              pwr_s,
  input  logic              rst_src,
  output hs_pkg::hs_state_e st,
  output logic              pg_stable
);
  import hs_pkg::*;
  localparam int unsigned SW = cnt_bits(SETTLE_CYC);
  localparam logic [SW-1:0] FULL = SW'(SETTLE_CYC);

  logic [SW-1:0] pg_cnt;
  hs_state_e     nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pg_cnt <= '0;
    else if (!pwr_s)     pg_cnt <= '0;
    else if (!pg_stable) pg_cnt <= pg_cnt + 1'b1;
  end
  assign pg_stable = (pg_cnt == FULL);

  always_comb begin
    nxt = st;
    if (!pwr_s && (st inside {ST_ISOLATED, ST_POWERING, ST_INSTALLED, ST_EXTRACTING})) begin
      nxt = ST_FAULT;
    end else begin
      case (st)
        ST_UNINST:     if (sel_act) nxt = ST_ISOLATED;
        ST_ISOLATED:   if (!sel_act) nxt = ST_UNINST;
                       else if (pg_stable && !rst_src) nxt = ST_POWERING;
        ST_POWERING:   if (!sel_act) nxt = ST_EXTRACTING;
                       else if (!rst_src) nxt = ST_INSTALLED;
        ST_INSTALLED:  if (!sel_act) nxt = ST_EXTRACTING;
                       else if (rst_src) nxt = ST_POWERING;
        ST_EXTRACTING: nxt = ST_UNINST;
        ST_FAULT:      if (!sel_act) nxt = ST_UNINST;
                       else if (pg_stable) nxt = ST_ISOLATED;
        default:       nxt = ST_UNINST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_UNINST;
    else        st <= nxt;
  end
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEB_CYC    = 50000,
  parameter int unsigned SETTLE_CYC = 25000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sel_n_raw,
  input  logic              pwr_good,
  input  logic              pri_rst_n,
  input  logic              bus_rst_n,
  input  logic              dual_conn,
  input  logic              rst_repeat_en,
  input  logic              pchg_drop_en,
  input  logic              clk_master_req,
  input  logic [DATA_W-1:0] data_req,
  input  logic              netref_req,
  input  logic              msg_req,
  output logic [DATA_W-1:0] data_oe,
  output logic              netref_oe,
  output logic              msg_en,
  output logic              clk_byp,
  output logic              pchg_en,
  output logic              fet_en,
  output logic              local_rst_n,
  output logic              bus_rst_drive,
  output logic              led
);
  import hs_pkg::*;

  // synchronized inputs: {select, power good, primary reset, bus reset}
  logic [3:0] raw_v, syn_v;
  logic       sel_s, pwr_s, pri_s, bus_s;
  logic       sel_deb, sel_act, rst_src, pg_stable, bus_live;
  hs_state_e  st_w;

  assign raw_v = {sel_n_raw, pwr_good, pri_rst_n, bus_rst_n};

  hs_sync #(.W(4), .INIT(4'b1000)) u_sync (
    .clk(clk), .rst_n(por_n), .d(raw_v), .q(syn_v)
  );
  assign {sel_s, pwr_s, pri_s, bus_s} = syn_v;

  hs_debounce #(.WINDOW(DEB_CYC), .INIT(1'b1)) u_deb (
    .clk(clk), .rst_n(por_n), .din(sel_s), .level(sel_deb)
  );
  assign sel_act = !sel_deb;

  hs_rst_sel u_rsel (
    .dual_conn(dual_conn), .rst_repeat_en(rst_repeat_en),
    .pri_rst_n_s(pri_s), .bus_rst_n_s(bus_s),
    .rst_src(rst_src), .rep_drive(bus_rst_drive)
  );

  hs_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(por_n), .sel_act(sel_act), .pwr_s(pwr_s),
    .rst_src(rst_src), .st(st_w), .pg_stable(pg_stable)
  );

  assign bus_live = (st_w == ST_INSTALLED) && pwr_s;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign data_oe[i] = bus_live & data_req[i];
  end

  assign netref_oe   = bus_live & netref_req;
  assign msg_en      = bus_live & msg_req;
  assign clk_byp     = bus_live & clk_master_req;
  assign local_rst_n = bus_live;
  assign fet_en      = backend_on(st_w) & pwr_s;
  assign pchg_en     = !(pchg_drop_en && pchg_droppable(st_w) && pwr_s);
  assign led         = !backend_on(st_w);
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic [2:0]        st,
  input logic              pwr_s,
  input logic              sel_s,
  input logic              sel_deb,
  input logic              dual_conn,
  input logic [DATA_W-1:0] data_oe,
  input logic              netref_oe,
  input logic              msg_en,
  input logic              clk_byp,
  input logic              fet_en,
  input logic              local_rst_n,
  input logic              bus_rst_drive,
  input logic              led
);
  import hs_pkg::*;

  p_debounce_follow_r2: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(sel_deb) |-> (sel_deb == $past(sel_s)));

  p_fet_before_release_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(local_rst_n) |-> (fet_en && $past(fet_en)));

  p_iso_in_reset_r4: assert property (@(posedge clk) disable iff (!por_n)
    !local_rst_n |-> (data_oe == '0 && !netref_oe && !msg_en));

  p_repeat_dual_r6: assert property (@(posedge clk) disable iff (!por_n)
    bus_rst_drive |-> dual_conn);

  p_bypass_live_r7: assert property (@(posedge clk) disable iff (!por_n)
    clk_byp |-> (local_rst_n && fet_en));

  p_ext_fet_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_EXTRACTING) |=> !fet_en);

  p_pwr_loss_fault_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!pwr_s && st != ST_UNINST && st != ST_FAULT) |=> (st == ST_FAULT));

  p_led_unpowered_r11: assert property (@(posedge clk) disable iff (!por_n)
    fet_en |-> !led);
endmodule

bind hotswap_seq hs_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .st(st_w), .pwr_s(pwr_s), .sel_s(sel_s),
  .sel_deb(sel_deb), .dual_conn(dual_conn), .data_oe(data_oe),
  .netref_oe(netref_oe), .msg_en(msg_en), .clk_byp(clk_byp),
  .fet_en(fet_en), .local_rst_n(local_rst_n),
  .bus_rst_drive(bus_rst_drive), .led(led)
);

// File: tb/tb_hotswap_seq.sv
`timescale 1ns/1ps
module tb_hotswap_seq;
  localparam int DW  = 32;
  localparam int DEB = 8;
  localparam int SET = 6;
  localparam logic [DW-1:0] REQ = 32'hA5C3_0F96;

  // {dual, repeat, pri_rst_n, bus_rst_n, master_req, exp_live, exp_byp, exp_drv}
  localparam logic [7:0] VEC [10] = '{
    8'b00110100, 8'b00101000, 8'b00011110, 8'b01010100, 8'b10101110,
    8'b10010000, 8'b11011001, 8'b11111110, 8'b11000001, 8'b00111110
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n, sel_n_raw, pwr_good, pri_rst_n, bus_rst_n, dual_conn;
  logic rst_repeat_en, pchg_drop_en, clk_master_req, netref_req, msg_req;
  logic [DW-1:0] data_req, data_oe;
  logic netref_oe, msg_en, clk_byp, pchg_en, fet_en, local_rst_n, bus_rst_drive, led;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  hotswap_seq #(.DATA_W(DW), .DEB_CYC(DEB), .SETTLE_CYC(SET)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic safe_check(input string req);
    chk(req, {32'd0, data_oe}, 64'd0);
    chk(req, {netref_oe, msg_en, clk_byp, fet_en, local_rst_n}, 5'b00000);
    chk(req, {pchg_en, led}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    por_n = 0; sel_n_raw = 1; pwr_good = 1; pri_rst_n = 1; bus_rst_n = 1;
    dual_conn = 0; rst_repeat_en = 0; pchg_drop_en = 1; clk_master_req = 1;
    data_req = '1; netref_req = 1; msg_req = 1;
    step(3);
    safe_check("R1 reset state");               // R1
    data_req = REQ;
    por_n = 1;
    step(12);
    safe_check("R10 unseated precharge");        // R10, R11

    // R2: bounce shorter than the window must leave the card unseated
    sel_n_raw = 0; step(DEB - 1); sel_n_raw = 1;
    step(DEB + 6);
    chk("R2 short bounce ignored", {pchg_en, led, fet_en}, 3'b110);

    // R2/R3: clean insertion, exact cycles
    sel_n_raw = 0;
    step(DEB + 2);
    chk("R2 before window", pchg_en, 1'b1);
    step(1);
    chk("R2 seated at window", pchg_en, 1'b0);
    chk("R3 fet waits", fet_en, 1'b0);
    chk("R7 no bypass while seating", clk_byp, 1'b0);
    chk("R11 led on unpowered", led, 1'b1);
    step(1);
    chk("R3 fet on", {fet_en, local_rst_n, led}, 3'b100);
    step(1);
    chk("R3 release after fet", {fet_en, local_rst_n}, 2'b11);
    chk("R4 lanes live", {32'd0, data_oe}, {32'd0, REQ});
    chk("R4 netref msg live", {netref_oe, msg_en}, 2'b11);

    // table of reset-source / strap vectors on an installed card
    for (int i = 0; i < 10; i++) begin
      {dual_conn, rst_repeat_en, pri_rst_n, bus_rst_n, clk_master_req} = VEC[i][7:3];
      step(6);
      chk($sformatf("R5 vec%0d local reset", i), local_rst_n, VEC[i][2]);
      chk($sformatf("R4 vec%0d lanes", i), {32'd0, data_oe}, VEC[i][2] ? {32'd0, REQ} : 64'd0);
      chk($sformatf("R7 vec%0d bypass", i), clk_byp, VEC[i][1]);
      chk($sformatf("R6 vec%0d repeat", i), bus_rst_drive, VEC[i][0]);
    end
    dual_conn = 0; rst_repeat_en = 0; pri_rst_n = 1; bus_rst_n = 1; clk_master_req = 1;
    step(6);

    // R9: power loss and recovery
    pwr_good = 0;
    step(1);
    chk("R9 fet before sync", fet_en, 1'b1);
    step(1);
    chk("R9 fet off", {fet_en, local_rst_n, clk_byp}, 3'b000);
    chk("R9 isolated", {32'd0, data_oe}, 64'd0);
    chk("R10 precharge on loss", pchg_en, 1'b1);
    step(3);
    chk("R11 led in fault", led, 1'b1);
    pwr_good = 1;
    step(SET + 3);
    chk("R9 settle not done", fet_en, 1'b0);
    step(1);
    chk("R9 fet after settle", {fet_en, local_rst_n}, 2'b10);
    step(1);
    chk("R9 recovered", local_rst_n, 1'b1);

    // R8: extraction order
    sel_n_raw = 1;
    step(DEB + 2);
    chk("R8 still installed", local_rst_n, 1'b1);
    step(1);
    chk("R8 reset+iso, fet on", {fet_en, local_rst_n, clk_byp, pchg_en}, 4'b1001);
    chk("R8 lanes off", {32'd0, data_oe}, 64'd0);
    step(1);
    chk("R8 fet off", {fet_en, led}, 2'b01);

    // R10: precharge retained when strap forbids dropping it
    pchg_drop_en = 0;
    sel_n_raw = 0;
    step(DEB + 8);
    chk("R10 installed keeps precharge", {local_rst_n, pchg_en}, 2'b11);

    // R1: asynchronous power-on reset mid-cycle
    @(posedge clk); #1;
    por_n = 0;
    #0.5;
    chk("R1 async lanes", {32'd0, data_oe}, 64'd0);
    chk("R1 async fet/reset", {fet_en, local_rst_n, led}, 3'b001);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule